// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block is a bank of 32 general-purpose pins that software controls through a small word-addressed register interface. Each pin is configured on its own. It can drive a value out, act as a plain input, or act as an input that can raise an interrupt. Every pin's input is brought into the core clock domain through a two-flop synchroniser before any other logic sees it.

A pin in interrupt mode uses its own trigger type: rising edge, falling edge, low level or high level. Edge events are held in a status register until software clears them by writing a 1 to the bit. For a pin with a level trigger, the status bit shows the live synchronised condition. All interrupt-mode pins share a single request line. A host reads the status register to find which pins fired.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset every pin is in plain-input mode with trigger rising edge. `gpio_oe`, `gpio_out` and `irq` are 0, and every register address reads 0 while the pins are held at 0.
- R2: A pin whose mode field is 2'b01 drives `gpio_oe`=1 and drives `gpio_out` to its bit of the output-data register (address 0). Every other pin has `gpio_oe`=0 and `gpio_out`=0. These outputs change only after a register write.
- R3: A read of address 5 returns the synchronised pin values for all pins, in any mode. A change on `gpio_in` is first visible after the second rising clock edge.
- R4: For a pin in interrupt mode with trigger 2'b00, a 0-to-1 input change sets its status bit (address 6) after the third rising edge. The bit stays set after the input returns to 0.
- R5: For a pin in interrupt mode with trigger 2'b01, a 1-to-0 change sets its status bit after the third rising edge. A 0-to-1 change sets nothing.
- R6: For a pin with trigger 2'b11 (high) or 2'b10 (low), the status bit equals the live synchronised condition. It clears by itself when the condition ends, with no write needed.
- R7: Writing address 6 clears each latched edge bit whose write-data bit is 1. Bits written 0 keep their value. An edge arriving in the same cycle as the clear wins.
- R8: `irq` is 1 exactly when some pin in interrupt mode (2'b10) has its status bit set. A pin in any other mode never latches an edge and never raises `irq`, though its level-trigger status still reads back.
- R9: Pins configured with different triggers detect their events independently and at the same time. Clearing one pin's status leaves the other pins' status unchanged.
- R10: Register map: 0 output data; 1 and 2 hold the 2-bit mode fields for pins 0–15 and pins 16–31 (pin k at bits 2k+1:2k of its word); 3 and 4 hold the 2-bit trigger fields in the same layout; 5 pin input (read-only); 6 status. Mode 2'b11 behaves as plain input, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from address) |
| gpio_in | input | 32 | Asynchronous pin inputs |
| gpio_out | output | 32 | Pin output values |
| gpio_oe | output | 32 | Pin output enables |
| irq | output | 1 | Shared interrupt request |

## Verification
A corrupted synchroniser or previous-value flop would move edge detection off its three-edge latency. It could also create phantom edges, and either fault shows up in the status read and on `irq` within one or two cycles of the pin change. A latched status bit that is lost or stuck stays visible at address 6 until software writes a clear. The bench checks that a zero write leaves the bit set and that a one write removes it. A wrong mode decode shows immediately on `gpio_oe`, or as an `irq` raised by a pin that is not in interrupt mode.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        PM_INPUT  = 2'b00,
        PM_OUTPUT = 2'b01,
        PM_IRQ    = 2'b10,
        PM_RSVD   = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        TR_RISE = 2'b00,
        TR_FALL = 2'b01,
        TR_LOW  = 2'b10,
        TR_HIGH = 2'b11
    } trig_e;

    localparam int AW = 3;

    localparam logic [AW-1:0] RA_DOUT    = 3'd0;
    localparam logic [AW-1:0] RA_MODE_LO = 3'd1;
    localparam logic [AW-1:0] RA_MODE_HI = 3'd2;
    localparam logic [AW-1:0] RA_TRIG_LO = 3'd3;
    localparam logic [AW-1:0] RA_TRIG_HI = 3'd4;
    localparam logic [AW-1:0] RA_PIN     = 3'd5;
    localparam logic [AW-1:0] RA_STAT    = 3'd6;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic level_hit(trig_e t, logic s);
        return ((t == TR_HIGH) && s) || ((t == TR_LOW) && !s);
    endfunction

    function automatic logic edge_hit(trig_e t, edge_t e);
        return ((t == TR_RISE) && e.rise) || ((t == TR_FALL) && e.fall);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [AW-1:0]          addr,
    input  logic [W-1:0]           wdata,
    output logic [W-1:0]           rdata,
    input  logic [W-1:0]           pin_sync,
    input  logic [W-1:0]           status,
    output logic [W-1:0]           dout,
    output pin_mode_e [W-1:0]      mode_a,
    output trig_e [W-1:0]          trig_a,
    output logic [W-1:0]           clr_mask
);
    localparam int HALF = W / 2;

    logic [W-1:0] mode_lo, mode_hi, trig_lo, trig_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout    <= '0;
            mode_lo <= '0;
            mode_hi <= '0;
            trig_lo <= '0;
            trig_hi <= '0;
        end else if (we) begin
            case (addr)
                RA_DOUT:    dout    <= wdata;
                RA_MODE_LO: mode_lo <= wdata;
                RA_MODE_HI: mode_hi <= wdata;
                RA_TRIG_LO: trig_lo <= wdata;
                RA_TRIG_HI: trig_hi <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < W; k++) begin : g_unpack
        if (k < HALF) begin : g_lo
            assign mode_a[k] = pin_mode_e'(mode_lo[2*k +: 2]);
            assign trig_a[k] = trig_e'(trig_lo[2*k +: 2]);
        end else begin : g_hi
            assign mode_a[k] = pin_mode_e'(mode_hi[2*(k-HALF) +: 2]);
            assign trig_a[k] = trig_e'(trig_hi[2*(k-HALF) +: 2]);
        end
    end

    assign clr_mask = (we && addr == RA_STAT) ? wdata : '0;

    always_comb begin
        case (addr)
            RA_DOUT:    rdata = dout;
            RA_MODE_LO: rdata = mode_lo;
            RA_MODE_HI: rdata = mode_hi;
            RA_TRIG_LO: rdata = trig_lo;
            RA_TRIG_HI: rdata = trig_hi;
            RA_PIN:     rdata = pin_sync;
            RA_STAT:    rdata = status;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      pin_sync,
    input  pin_mode_e [W-1:0] mode_a,
    input  trig_e [W-1:0]     trig_a,
    input  logic [W-1:0]      clr_mask,
    output logic [W-1:0]      latched,
    output logic [W-1:0]      status,
    output logic [W-1:0]      irq_en
);
    logic [W-1:0] prev;
    logic [W-1:0] latch_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            latched <= '0;
        end else begin
            prev    <= pin_sync;
            latched <= latch_d;
        end
    end

    for (genvar k = 0; k < W; k++) begin : g_pin
        edge_t ev;
        logic  set_k;
        assign ev.rise   = pin_sync[k] & ~prev[k];
        assign ev.fall   = ~pin_sync[k] & prev[k];
        assign irq_en[k] = (mode_a[k] == PM_IRQ);
        assign set_k     = irq_en[k] && edge_hit(trig_a[k], ev);
        assign latch_d[k] = set_k | (latched[k] & ~clr_mask[k]);
        assign status[k]  = latched[k] | level_hit(trig_a[k], pin_sync[k]);
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    input  logic [W-1:0]  gpio_in,
    output logic [W-1:0]  gpio_out,
    output logic [W-1:0]  gpio_oe,
    output logic          irq
);
    logic [W-1:0]      pin_sync;
    logic [W-1:0]      status;
    logic [W-1:0]      latched;
    logic [W-1:0]      irq_en;
    logic [W-1:0]      dout;
    logic [W-1:0]      clr_mask;
    pin_mode_e [W-1:0] mode_a;
    trig_e [W-1:0]     trig_a;

    gpio_sync #(.W(W)) u_sync (
        .clk(clk), .rst(rst), .din(gpio_in), .dout(pin_sync)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .pin_sync(pin_sync),
        .status(status), .dout(dout), .mode_a(mode_a), .trig_a(trig_a),
        .clr_mask(clr_mask)
    );

    gpio_detect #(.W(W)) u_detect (
        .clk(clk), .rst(rst), .pin_sync(pin_sync), .mode_a(mode_a),
        .trig_a(trig_a), .clr_mask(clr_mask), .latched(latched),
        .status(status), .irq_en(irq_en)
    );

    for (genvar k = 0; k < W; k++) begin : g_drive
        assign gpio_oe[k]  = (mode_a[k] == PM_OUTPUT);
        assign gpio_out[k] = gpio_oe[k] & dout[k];
    end

    assign irq = |(status & irq_en);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] gpio_in,
    input logic [W-1:0] gpio_oe,
    input logic         irq,
    input logic         reg_we,
    input logic [2:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] pin_sync,
    input logic [W-1:0] latched,
    input logic [W-1:0] irq_en
);
    logic [1:0]   warm_cnt;
    logic [W-1:0] clr_bits;

    always_ff @(posedge clk) begin
        if (rst)                  warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end

    assign clr_bits = (reg_we && reg_addr == 3'd6) ? reg_wdata : '0;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == 2'd0) |-> (gpio_oe == '0 && !irq)); // R1

    AST_OE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt != 2'd0 && !$past(reg_we)) |-> $stable(gpio_oe)); // R2

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt >= 2'd2) |-> (pin_sync == $past(gpio_in, 2))); // R3

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt != 2'd0) |-> (($past(latched) & ~$past(clr_bits) & ~latched) == '0)); // R4

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en != '0)); // R8

    AST_LATCH_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt != 2'd0) |-> ((latched & ~$past(latched) & ~$past(irq_en)) == '0)); // R8
endmodule

bind gpio_bank gpio_bank_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .gpio_in(gpio_in), .gpio_oe(gpio_oe), .irq(irq),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pin_sync(pin_sync), .latched(latched), .irq_en(irq_en)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
    localparam int W = 32;
    localparam int NV = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         reg_we;
    logic [2:0]   reg_addr;
    logic [W-1:0] reg_wdata;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] gpio_in;
    logic [W-1:0] gpio_out;
    logic [W-1:0] gpio_oe;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    gpio_bank #(.W(W)) u_gpio_bank (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
    );

    // vector: {mode_lo, mode_hi, dout, pins}
    localparam logic [127:0] VEC [NV] = '{
        {32'h5555_5555, 32'h0000_0000, 32'hA5A5_F00F, 32'h1234_5678},
        {32'h0000_0000, 32'h5555_5555, 32'hFFFF_FFFF, 32'hDEAD_BEEF},
        {32'h1111_1111, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0000_FFFF},
        {32'hAAAA_AAAA, 32'h4444_4444, 32'h8000_0001, 32'h0000_0000}
    };

    function automatic logic [W-1:0] model_oe(logic [W-1:0] lo, logic [W-1:0] hi);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) begin
            logic [1:0] f;
            f = (k < W/2) ? lo[2*k +: 2] : hi[2*(k-W/2) +: 2];
            r[k] = (f == 2'b01);
        end
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [W-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1; gpio_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] v;
        do_reset();

        // R1 reset state
        check("R1 oe", gpio_oe, '0);
        check("R1 out", gpio_out, '0);
        check("R1 irq", {31'b0, irq}, '0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reg read", v, '0);
        end

        // R2 R3 R10 table walk
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] mlo, mhi, dv, pv, eoe;
            {mlo, mhi, dv, pv} = VEC[i];
            do_reset();
            wr(3'd1, mlo);
            wr(3'd2, mhi);
            wr(3'd0, dv);
            gpio_in = pv;
            repeat (3) @(negedge clk);
            eoe = model_oe(mlo, mhi);
            check("R2 R10 oe", gpio_oe, eoe);
            check("R2 out", gpio_out, eoe & dv);
            rd(3'd5, v);
            check("R3 pin read", v, pv);
            check("R8 no irq", {31'b0, irq}, '0);
        end

        // R3 latency
        do_reset();
        gpio_in = 32'h8000_0003;
        @(negedge clk);
        rd(3'd5, v);
        check("R3 one edge", v, '0);
        @(negedge clk);
        rd(3'd5, v);
        check("R3 two edges", v, 32'h8000_0003);
        rd(3'd7, v);
        check("R10 addr7", v, '0);

        // R4 rising edge latch
        do_reset();
        wr(3'd1, 32'h0000_0002);
        gpio_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd6, v);
        check("R4 before third edge", v, '0);
        @(negedge clk);
        rd(3'd6, v);
        check("R4 latched", v, 32'h1);
        check("R4 irq", {31'b0, irq}, 32'h1);
        gpio_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd6, v);
        check("R4 sticky", v, 32'h1);

        // R7 write-one-to-clear
        wr(3'd6, 32'hFFFF_FFFE);
        rd(3'd6, v);
        check("R7 zero keeps", v, 32'h1);
        wr(3'd6, 32'h0000_0001);
        rd(3'd6, v);
        check("R7 one clears", v, '0);
        check("R7 irq drops", {31'b0, irq}, '0);

        // R5 falling edge
        do_reset();
        gpio_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        wr(3'd3, 32'h0000_0004);
        wr(3'd1, 32'h0000_0008);
        gpio_in[1] = 1'b0;
        repeat (3) @(negedge clk);
        rd(3'd6, v);
        check("R5 fall latched", v, 32'h2);
        check("R5 irq", {31'b0, irq}, 32'h1);
        wr(3'd6, 32'h2);
        gpio_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd6, v);
        check("R5 rise ignored", v, '0);

        // R6 level high
        do_reset();
        wr(3'd3, 32'h0000_0030);
        wr(3'd1, 32'h0000_0020);
        gpio_in[2] = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd6, v);
        check("R6 high level", v, 32'h4);
        check("R6 irq high", {31'b0, irq}, 32'h1);
        gpio_in[2] = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd6, v);
        check("R6 high released", v, '0);
        check("R6 irq released", {31'b0, irq}, '0);

        // R6 level low on upper half
        do_reset();
        wr(3'd4, 32'h0000_0200);
        wr(3'd2, 32'h0000_0200);
        rd(3'd6, v);
        check("R6 low level", v, 32'h0010_0000);
        check("R6 irq low", {31'b0, irq}, 32'h1);
        gpio_in[20] = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd6, v);
        check("R6 low released", v, '0);

        // R8 non-interrupt pins
        do_reset();
        wr(3'd3, 32'h0000_00C0);
        gpio_in[3] = 1'b1;
        gpio_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        rd(3'd6, v);
        check("R8 status without enable", v, 32'h8);
        check("R8 irq masked", {31'b0, irq}, '0);
        wr(3'd1, 32'h0000_0080);
        check("R8 irq enabled", {31'b0, irq}, 32'h1);

        // R9 independent pins
        do_reset();
        gpio_in[5] = 1'b1;
        repeat (4) @(negedge clk);
        wr(3'd3, 32'h0000_3400);
        wr(3'd1, 32'h0000_2A00);
        gpio_in[4] = 1'b1;
        gpio_in[5] = 1'b0;
        gpio_in[6] = 1'b1;
        repeat (3) @(negedge clk);
        rd(3'd6, v);
        check("R9 three triggers", v, 32'h70);
        wr(3'd6, 32'h10);
        rd(3'd6, v);
        check("R9 R7 selective clear", v, 32'h60);

        finish_run();
    end
endmodule